// File: doc/BRIEF.md
# Microcoded Control Sequencer for an 8-bit Accumulator Machine

This block is the control unit of a small single-bus 8-bit accumulator computer. A three-bit micro-step counter and the four-bit opcode held by the instruction register together select one slot of a fixed microcode table. Each slot is a 16-bit control word that carries one strobe for each register load, register drive, ALU function, program-counter action and the halt request. The registers, memory, ALU and bus that these strobes steer sit outside the block.

Every instruction owns eight slots. The first two slots form a shared fetch. The slots after the fetch carry the instruction's own execute steps, and any slot not used is all zero. The step counter moves forward once per clock and wraps back to the fetch. A halt instruction freezes the sequencer until reset. The control word is decoded combinationally from the registered step and the opcode input, so it holds steady for the whole cycle. The opcode is read as a level.

Top module: `ctl_sequencer`

## Requirements
- R1: Control word bit positions, from bit 15 down to bit 1, are: halt, memory-address load, RAM write, RAM drive, instruction-register drive, instruction-register load, accumulator load, accumulator drive, ALU drive, ALU subtract, B-operand load, display load, PC increment, PC drive, PC load. Bit 0 is always 0.
- R2: In step 0 the control word for every opcode is 16'h4004 (PC drive and memory-address load).
- R3: In step 1 the control word for every opcode is 16'h1408 (RAM drive, instruction-register load and PC increment).
- R4: Execute steps use these opcodes and words. Load-from-memory 4'b0001: step 2 16'h4800, step 3 16'h1200. Store 4'b0100: step 2 16'h4800, step 3 16'h2100. Load-immediate 4'b0101: step 2 16'h0A00. Jump 4'b0110: step 2 16'h0802. Display 4'b1110: step 2 16'h0110.
- R5: Add 4'b0010 gives step 2 16'h4800, step 3 16'h1020 and step 4 16'h0280. Subtract 4'b0011 gives the same words, except that step 4 is 16'h02C0.
- R6: Opcode 4'b0000 and opcodes 4'b0111 through 4'b1101 output only the fetch. Any slot not listed in R2 to R5 or R8 outputs 16'h0000.
- R7: The step output counts up by one on each rising clock edge and wraps from 7 to 0.
- R8: Halt opcode 4'b1111 outputs 16'h8000 in step 2 and raises the halt output. The step then stays at 2, and halt stays high.
- R9: After the halt, the control word stays 16'h8000 whatever the opcode input does, until reset.
- R10: Driving rst_n low at once sets the step to 0 and clears the halt. After rst_n is released, the step stays 0 through the first two rising edges and reaches 1 on the third.
- R11: The control word follows an opcode change within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| opcode | input | 4 | Opcode nibble from the instruction register |
| ctrl_word | output | 16 | Control strobes for the current cycle |
| step | output | 3 | Current micro-step number |
| halt | output | 1 | High while the halt word is driven and the machine is stopped |

## Verification
The bench walks all sixteen opcodes through all eight steps in one run without reset. This shows that every unused slot is zero, which a table that leaked fetch or execute bits into spare slots would break, and that the counter wraps from 7 into the next fetch, which an off-by-one counter would miss. After the halt it changes the opcode. A design that kept decoding the table would then leave the halt word, and a counter without a freeze would walk on past step 2. It also checks that reset lands mid-instruction without waiting for a clock edge, that release takes two edges, and that an opcode change shows on the control word before the next edge, which catches a design that pipelines the table output.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  localparam int CW_W   = 16;
  localparam int OP_W   = 4;
  localparam int STEP_W = 3;

  // Control word bit positions (downstream decodes these)
  localparam int B_HALT    = 15;
  localparam int B_MAR_LD  = 14;
  localparam int B_RAM_WR  = 13;
  localparam int B_RAM_DRV = 12;
  localparam int B_IR_DRV  = 11;
  localparam int B_IR_LD   = 10;
  localparam int B_ACC_LD  = 9;
  localparam int B_ACC_DRV = 8;
  localparam int B_SUM_DRV = 7;
  localparam int B_SUB_SEL = 6;
  localparam int B_OPB_LD  = 5;
  localparam int B_DISP_LD = 4;
  localparam int B_PC_INC  = 3;
  localparam int B_PC_DRV  = 2;
  localparam int B_PC_LD   = 1;

  typedef logic [CW_W-1:0] cw_t;

  function automatic cw_t bitw(input int pos);
    cw_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 4'b0000,
    OP_LDM   = 4'b0001,
    OP_ADDM  = 4'b0010,
    OP_SUBM  = 4'b0011,
    OP_STM   = 4'b0100,
    OP_LDIMM = 4'b0101,
    OP_GOTO  = 4'b0110,
    OP_SHOW  = 4'b1110,
    OP_STOP  = 4'b1111
  } op_e;

  localparam cw_t HALT_WORD = cw_t'(1) << B_HALT;
endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_ok
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign run_ok = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
      assign run_ok = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ctl_step_counter.sv
module ctl_step_counter #(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              run_ok,
  input  logic              halt_req,
  output logic [STEP_W-1:0] step,
  output logic              halted
);
  logic [STEP_W-1:0] step_q, step_d;
  logic              halted_q, halted_d;
  logic              adv_en;

  assign adv_en = !halt_req && !halted_q;

  always_comb begin
    step_d   = step_q;
    halted_d = halted_q;
    if (adv_en) step_d = step_q + STEP_W'(1);
    if (halt_req) halted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge run_ok) begin
    if (!run_ok) begin
      step_q   <= '0;
      halted_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      halted_q <= halted_d;
    end
  end

  assign step   = step_q;
  assign halted = halted_q;
endmodule

// File: rtl/ctl_ucode_rom.sv
module ctl_ucode_rom
  import ctl_seq_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int STEP_W = 3
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [STEP_W-1:0] step,
  output cw_t               word
);
  localparam cw_t FETCH_A = bitw(B_PC_DRV) | bitw(B_MAR_LD);
  localparam cw_t FETCH_B = bitw(B_RAM_DRV) | bitw(B_IR_LD) | bitw(B_PC_INC);
  localparam cw_t ADDR_LD = bitw(B_IR_DRV) | bitw(B_MAR_LD);

  cw_t exec_w;

  always_comb begin
    exec_w = '0;
    unique case (opcode)
      OP_LDM: begin
        if (step == 3'd2) exec_w = ADDR_LD;
        if (step == 3'd3) exec_w = bitw(B_RAM_DRV) | bitw(B_ACC_LD);
      end
      OP_ADDM, OP_SUBM: begin
        if (step == 3'd2) exec_w = ADDR_LD;
        if (step == 3'd3) exec_w = bitw(B_RAM_DRV) | bitw(B_OPB_LD);
        if (step == 3'd4) begin
          exec_w = bitw(B_SUM_DRV) | bitw(B_ACC_LD);
          if (opcode == OP_SUBM) exec_w = exec_w | bitw(B_SUB_SEL);
        end
      end
      OP_STM: begin
        if (step == 3'd2) exec_w = ADDR_LD;
        if (step == 3'd3) exec_w = bitw(B_ACC_DRV) | bitw(B_RAM_WR);
      end
      OP_LDIMM: if (step == 3'd2) exec_w = bitw(B_IR_DRV) | bitw(B_ACC_LD);
      OP_GOTO:  if (step == 3'd2) exec_w = bitw(B_IR_DRV) | bitw(B_PC_LD);
      OP_SHOW:  if (step == 3'd2) exec_w = bitw(B_ACC_DRV) | bitw(B_DISP_LD);
      OP_STOP:  if (step == 3'd2) exec_w = HALT_WORD;
      default:  exec_w = '0;
    endcase
  end

  always_comb begin
    if (step == '0)               word = FETCH_A;
    else if (step == STEP_W'(1))  word = FETCH_B;
    else                          word = exec_w;
  end
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
  import ctl_seq_pkg::*;
#(
  parameter int OPW   = 4,
  parameter int STEPW = 3,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPW-1:0]   opcode,
  output logic [15:0]      ctrl_word,
  output logic [STEPW-1:0] step,
  output logic             halt
);
  logic run_ok;
  logic halted;
  cw_t  rom_word;

  ctl_rst_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok)
  );

  ctl_ucode_rom #(.OP_W(OPW), .STEP_W(STEPW)) u_rom (
    .opcode(opcode), .step(step), .word(rom_word)
  );

  ctl_step_counter #(.STEP_W(STEPW)) u_cnt (
    .clk(clk), .run_ok(run_ok), .halt_req(rom_word[B_HALT]),
    .step(step), .halted(halted)
  );

  assign ctrl_word = halted ? HALT_WORD : rom_word;
  assign halt      = ctrl_word[B_HALT];
endmodule

// File: rtl/ctl_sequencer_chk.sv
module ctl_sequencer_chk #(
  parameter int STEPW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_ok,
  input logic [15:0]      ctrl_word,
  input logic [STEPW-1:0] step,
  input logic             halt
);
  p_bit0_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[0] == 1'b0);

  p_fetch_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |-> ctrl_word == 16'h4004);

  p_step_adv_r7: assert property (@(posedge clk) disable iff (!run_ok)
    !halt |=> step == $past(step) + STEPW'(1));

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!run_ok)
    halt |=> halt && $stable(step));

  p_halt_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> ctrl_word == 16'h8000);

  p_reset_clear_r10: assert property (@(posedge clk)
    !run_ok |-> (step == '0 && !halt));
endmodule

bind ctl_sequencer ctl_sequencer_chk #(.STEPW(STEPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_ok(run_ok),
  .ctrl_word(ctrl_word), .step(step), .halt(halt)
);

// File: tb/ctl_sequencer_bench.sv
`timescale 1ns/1ps
module ctl_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opcode;
  logic [15:0] ctrl_word;
  logic [2:0]  step;
  logic        halt;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctl_sequencer u_ctl_sequencer (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .ctrl_word(ctrl_word), .step(step), .halt(halt)
  );

  // Per opcode: {step2, step3, step4} execute words
  localparam logic [47:0] EXEC [16] = '{
    {16'h0000, 16'h0000, 16'h0000},
    {16'h4800, 16'h1200, 16'h0000},
    {16'h4800, 16'h1020, 16'h0280},
    {16'h4800, 16'h1020, 16'h02C0},
    {16'h4800, 16'h2100, 16'h0000},
    {16'h0A00, 16'h0000, 16'h0000},
    {16'h0802, 16'h0000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0000, 16'h0000, 16'h0000},
    {16'h0110, 16'h0000, 16'h0000},
    {16'h8000, 16'h0000, 16'h0000}
  };

  function automatic logic [15:0] exp_word(input int op, input int s);
    if (s == 0) return 16'h4004;
    if (s == 1) return 16'h1408;
    if (s == 2) return EXEC[op][47:32];
    if (s == 3) return EXEC[op][31:16];
    if (s == 4) return EXEC[op][15:0];
    return 16'h0000;
  endfunction

  function automatic string word_req(input int op, input int s);
    if (s == 0) return "R2";
    if (s == 1) return "R3";
    if (op == 2 || op == 3) return "R5";
    if (op == 1 || (op >= 4 && op <= 6) || op == 14) return "R4";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5 * 4000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    opcode = 4'h0;
    tick(); tick();
    chk("R10 step in reset", 32'(step), 32'd0);
    chk("R10 halt in reset", 32'(halt), 32'd0);
    chk("R2 word in reset", 32'(ctrl_word), 32'h4004);

    rst_n = 1'b1;
    tick();
    chk("R10 step after edge1", 32'(step), 32'd0);
    tick();
    chk("R10 step after edge2", 32'(step), 32'd0);

    // Table walk: opcodes 0..14, all steps, no reset between (R7 wrap)
    for (int op = 0; op < 15; op++) begin
      opcode = 4'(op);
      #0.1;
      for (int s = 0; s < 8; s++) begin
        chk((s == 0) ? "R7 step wrap/count" : "R7 step count", 32'(step), 32'(s));
        chk(word_req(op, s), 32'(ctrl_word), 32'(exp_word(op, s)));
        chk("R1 bit0 zero", 32'(ctrl_word[0]), 32'd0);
        tick();
      end
    end

    // Halt
    opcode = 4'hF;
    #0.1;
    chk("R8 fetch before halt", 32'(ctrl_word), 32'h4004);
    tick();
    chk("R8 fetch2 before halt", 32'(ctrl_word), 32'h1408);
    chk("R8 no halt in fetch", 32'(halt), 32'd0);
    tick();
    chk("R8 halt word", 32'(ctrl_word), 32'h8000);
    chk("R8 halt high", 32'(halt), 32'd1);
    for (int k = 0; k < 4; k++) tick();
    chk("R8 step frozen", 32'(step), 32'd2);
    chk("R8 halt held", 32'(halt), 32'd1);
    opcode = 4'h1;
    #0.5;
    chk("R9 word after opcode change", 32'(ctrl_word), 32'h8000);
    tick();
    chk("R9 still halted", 32'(halt), 32'd1);
    chk("R9 step still frozen", 32'(step), 32'd2);

    // Async reset out of halt
    #0.7;
    rst_n = 1'b0;
    #0.3;
    chk("R10 async step", 32'(step), 32'd0);
    chk("R10 async halt clear", 32'(halt), 32'd0);
    chk("R2 fetch word for new opcode", 32'(ctrl_word), 32'h4004);
    tick();
    rst_n = 1'b1;
    tick(); tick();
    chk("R10 step held after release", 32'(step), 32'd0);
    tick();
    chk("R10 step 1 on third edge", 32'(step), 32'd1);
    tick();
    chk("R4 load step2", 32'(ctrl_word), 32'h4800);

    // Same-cycle opcode follow
    opcode = 4'h6;
    #0.5;
    chk("R11 word follows opcode", 32'(ctrl_word), 32'h0802);
    opcode = 4'hE;
    #0.5;
    chk("R11 word follows opcode again", 32'(ctrl_word), 32'h0110);
    chk("R11 step unchanged", 32'(step), 32'd2);

    // Mid-instruction reset
    tick();
    rst_n = 1'b0;
    #0.3;
    chk("R10 mid-instruction reset", 32'(step), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule